// File: doc/BRIEF.md
# CPU Card Address Decode and Bus Strobe Glue

This block is the combinational glue between an 8-bit CPU with a 16-bit address bus and the parts on its card. It looks at the address, the read/not-write line and a bus clock. From these it drives active-low selects for an on-board RAM, an on-board ROM and one 256-byte external I/O page. It also drives a read strobe and a write strobe, both qualified by the clock.

The I/O page is picked by an 8-bit switch value. That value is compared against the upper address byte. Where the I/O page overlaps RAM or ROM, the I/O page wins. A 2-bit split code moves the RAM/ROM boundary to one of three positions. The ROM always ends at the top of the address space, so it always holds the reset and interrupt vectors.

A clock-select input picks which clock qualifies the strobes:
- the master oscillator, or
- the CPU's buffered phase-2 output.

The polarity is positive inside the block and is inverted only at the ports.

Top module: `mem_glue_dec`

## Requirements
- R1: With split_i = 0, addresses 0x0000–0xDFFF select RAM and 0xE000–0xFFFF select ROM, apart from the I/O page.
- R2: With split_i = 1, addresses 0x0000–0xBFFF select RAM and 0xC000–0xFFFF select ROM, apart from the I/O page.
- R3: With split_i = 2, addresses 0x0000–0x7FFF select RAM and 0x8000–0xFFFF select ROM, apart from the I/O page.
- R4: io_cs_no is low exactly when addr_i[15:8] equals io_bank_i.
- R5: While io_cs_no is low, ram_cs_no and rom_cs_no are both high. The I/O page overrides memory.
- R6: For every address, exactly one of ram_cs_no, rom_cs_no and io_cs_no is low.
- R7: Addresses 0xFFFA–0xFFFF select ROM in every split, unless io_bank_i is 0xFF.
- R8: With clk_sel_i = 0 the strobes follow osc_clk_i. With clk_sel_i = 1 they follow phi2_i.
- R9: rd_no is low exactly when the selected clock is high and rnw_i is 1. wr_no is low exactly when the selected clock is high and rnw_i is 0.
- R10: The split code 3 decodes the same as split code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | CPU address bus |
| rnw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| osc_clk_i | input | 1 | Master oscillator clock |
| phi2_i | input | 1 | CPU phase-2 clock output |
| clk_sel_i | input | 1 | Strobe clock source: 0 = oscillator, 1 = phase-2 |
| split_i | input | 2 | RAM/ROM split: 0 = 56K/8K, 1 = 48K/16K, 2 = 32K/32K, 3 = as 0 |
| io_bank_i | input | 8 | Switch value naming the I/O page (address bits 15..8) |
| ram_cs_no | output | 1 | RAM select, active low |
| rom_cs_no | output | 1 | ROM select, active low |
| io_cs_no | output | 1 | I/O page select, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
The bench sweeps all 65536 addresses under every split code and compares each one with the expected select. This exposes a boundary off by one page, which would select RAM for the first ROM page or the reverse. It also exposes a wrong fallback for code 3, which would move the boundary. It then moves the I/O page through low, mid, boundary-straddling and top banks:
- If priority were missing, two selects would go low together on the I/O page.
- If the compare were dropped or reversed, a page would decode as memory.

Strobes are checked in both clock phases with each clock source. A swapped source or a missing read/write qualifier shows up as a strobe that is active while the chosen clock is low, or active in the wrong direction.

// File: rtl/glue_pkg.sv
`timescale 1ns/1ps
package glue_pkg;
  typedef enum logic [1:0] {
    SPLIT_56_8  = 2'd0,
    SPLIT_48_16 = 2'd1,
    SPLIT_32_32 = 2'd2,
    SPLIT_ALT   = 2'd3
  } split_e;

  localparam int SPLIT_W = 2;
endpackage

// File: rtl/glue_region_dec.sv
`timescale 1ns/1ps
// RAM/ROM region split from the top address bits
module glue_region_dec
  import glue_pkg::*;
#(
  parameter int TOP_W = 3
) (
  input  logic [TOP_W-1:0]   top_i,
  input  logic [SPLIT_W-1:0] split_i,
  input  logic               io_hit_i,
  output logic               ram_hit_o,
  output logic               rom_hit_o
);
  logic rom_region;

  always_comb begin
    unique case (split_e'(split_i))
      SPLIT_48_16: rom_region = &top_i[TOP_W-1 -: 2];
      SPLIT_32_32: rom_region = top_i[TOP_W-1];
      default:     rom_region = &top_i;  // 56/8 and spare code
    endcase
  end

  // I/O page overrides both memories
  assign rom_hit_o = rom_region & ~io_hit_i;
  assign ram_hit_o = ~rom_region & ~io_hit_i;
endmodule

// File: rtl/glue_io_match.sv
`timescale 1ns/1ps
// Page equality compare against the switch bank
module glue_io_match #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PAGE_W-1:0] bank_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] bit_eq;

  for (genvar b = 0; b < PAGE_W; b++) begin : g_eq
    assign bit_eq[b] = ~(page_i[b] ^ bank_i[b]);
  end

  assign hit_o = &bit_eq;
endmodule

// File: rtl/glue_strobe.sv
`timescale 1ns/1ps
// Clock source mux and qualified bus strobes
module glue_strobe (
  input  logic osc_clk_i,
  input  logic phi2_i,
  input  logic clk_sel_i,
  input  logic rnw_i,
  output logic rd_o,
  output logic wr_o
);
  logic bus_clk;

  assign bus_clk = clk_sel_i ? phi2_i : osc_clk_i;
  assign rd_o    = bus_clk & rnw_i;
  assign wr_o    = bus_clk & ~rnw_i;

  // R8 R9: oscillator sampled high at its falling edge
  osc_strobe_chk: assert property (@(negedge osc_clk_i)
    !clk_sel_i |-> (rd_o == rnw_i && wr_o == !rnw_i));

  // R8 R9
  phi2_idle_chk: assert property (@(negedge osc_clk_i)
    (clk_sel_i && !phi2_i) |-> (!rd_o && !wr_o));
endmodule

// File: rtl/mem_glue_dec.sv
`timescale 1ns/1ps
module mem_glue_dec
  import glue_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rnw_i,
  input  logic               osc_clk_i,
  input  logic               phi2_i,
  input  logic               clk_sel_i,
  input  logic [SPLIT_W-1:0] split_i,
  input  logic [PAGE_W-1:0]  io_bank_i,
  output logic               ram_cs_no,
  output logic               rom_cs_no,
  output logic               io_cs_no,
  output logic               rd_no,
  output logic               wr_no
);
  localparam int TOP_W = 3;
  localparam logic [ADDR_W-1:0] VEC_LO = {{(ADDR_W-3){1'b1}}, 3'b010};

  logic io_hit, ram_hit, rom_hit, rd_act, wr_act;

  glue_io_match #(.PAGE_W(PAGE_W)) u_io_match (
    .page_i (addr_i[ADDR_W-1 -: PAGE_W]),
    .bank_i (io_bank_i),
    .hit_o  (io_hit)
  );

  glue_region_dec #(.TOP_W(TOP_W)) u_region (
    .top_i     (addr_i[ADDR_W-1 -: TOP_W]),
    .split_i   (split_i),
    .io_hit_i  (io_hit),
    .ram_hit_o (ram_hit),
    .rom_hit_o (rom_hit)
  );

  glue_strobe u_strobe (
    .osc_clk_i (osc_clk_i),
    .phi2_i    (phi2_i),
    .clk_sel_i (clk_sel_i),
    .rnw_i     (rnw_i),
    .rd_o      (rd_act),
    .wr_o      (wr_act)
  );

  assign ram_cs_no = ~ram_hit;
  assign rom_cs_no = ~rom_hit;
  assign io_cs_no  = ~io_hit;
  assign rd_no     = ~rd_act;
  assign wr_no     = ~wr_act;

  // R6
  one_sel_chk: assert property (@(posedge osc_clk_i)
    $countones({ram_cs_no, rom_cs_no, io_cs_no}) == 2);

  // R5
  io_prio_chk: assert property (@(posedge osc_clk_i)
    !io_cs_no |-> (ram_cs_no && rom_cs_no));

  // R7
  vec_rom_chk: assert property (@(posedge osc_clk_i)
    (addr_i >= VEC_LO && io_cs_no) |-> !rom_cs_no);

  // R3
  half_ram_chk: assert property (@(posedge osc_clk_i)
    (split_i == 2'd2 && !addr_i[ADDR_W-1] && io_cs_no) |-> !ram_cs_no);
endmodule

// File: tb/mem_glue_dec_bench.sv
`timescale 1ns/1ps
module mem_glue_dec_bench;
  typedef struct {
    logic [4:0]  exp;   // {ram,rom,io,rd,wr} active-low
    logic [15:0] addr;
    string       tag;
  } item_t;

  logic [15:0] addr_i = '0;
  logic        rnw_i = 1'b1, osc_clk_i = 1'b0, phi2_i = 1'b0, clk_sel_i = 1'b0;
  logic [1:0]  split_i = '0;
  logic [7:0]  io_bank_i = 8'hE0;
  logic ram_cs_no, rom_cs_no, io_cs_no, rd_no, wr_no;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  item_t q[$];
  event  ev;

  always #4 osc_clk_i = ~osc_clk_i;  // 125 MHz

  mem_glue_dec u_mem_glue_dec (
    .addr_i, .rnw_i, .osc_clk_i, .phi2_i, .clk_sel_i, .split_i, .io_bank_i,
    .ram_cs_no, .rom_cs_no, .io_cs_no, .rd_no, .wr_no
  );

  function automatic logic [4:0] model(logic [15:0] a, logic [1:0] sp,
                                       logic [7:0] bank, logic rnw, logic sclk);
    logic io, rom, ram;
    io = (a[15:8] == bank);
    case (sp)
      2'd1:    rom = (a >= 16'hC000);
      2'd2:    rom = (a >= 16'h8000);
      default: rom = (a >= 16'hE000);  // R10 code 3 as code 0
    endcase
    rom = rom & ~io;
    ram = ~rom & ~io & ~(a[15:8] == bank);
    return {~ram, ~rom, ~io, ~(sclk & rnw), ~(sclk & ~rnw)};
  endfunction

  // driver: set inputs, then queue expectation
  task automatic apply(logic [15:0] a, logic [1:0] sp, logic [7:0] bank,
                       logic rnw, logic sel, logic p2, string tag);
    item_t it;
    addr_i = a; split_i = sp; io_bank_i = bank;
    rnw_i = rnw; clk_sel_i = sel; phi2_i = p2;
    #0.4;
    it.exp  = model(a, sp, bank, rnw, sel ? p2 : osc_clk_i);
    it.addr = a;
    it.tag  = tag;
    q.push_back(it);
    ->ev;
    #0.6;
  endtask

  // monitor
  initial forever begin
    @(ev);
    while (q.size() > 0) begin
      item_t it;
      logic [4:0] got;
      it  = q.pop_front();
      got = {ram_cs_no, rom_cs_no, io_cs_no, rd_no, wr_no};
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h ram/rom/io/rd/wr got=%b exp=%b",
                 it.tag, it.addr, got, it.exp);
      end
    end
  end

  function automatic string split_tag(logic [1:0] sp);
    case (sp)
      2'd1: return "R2 R6";
      2'd2: return "R3 R6";
      2'd3: return "R10 R6";
      default: return "R1 R6";
    endcase
  endfunction

  initial begin
    #100.5;
    apply(16'h0000, 2'd0, 8'hE0, 1'b1, 1'b0, 1'b0, "R1 initial");
    // full sweeps per split, I/O bank at E0
    for (int sp = 0; sp < 4; sp++)
      for (int a = 0; a < 65536; a++)
        apply(16'(a), 2'(sp), 8'hE0, 1'(a[0]), 1'b0, 1'b0, split_tag(2'(sp)));
    // bank moves: R4 R5, both ends of every page
    begin
      logic [7:0] banks[6] = '{8'h00, 8'h7F, 8'hC0, 8'hDF, 8'hE0, 8'hFF};
      for (int b = 0; b < 6; b++)
        for (int sp = 0; sp < 3; sp++)
          for (int p = 0; p < 256; p++) begin
            apply({8'(p), 8'h00}, 2'(sp), banks[b], 1'b1, 1'b0, 1'b0, "R4 R5");
            apply({8'(p), 8'hFF}, 2'(sp), banks[b], 1'b0, 1'b0, 1'b0, "R4 R5");
          end
    end
    // vectors: R7
    for (int sp = 0; sp < 4; sp++)
      for (int a = 16'hFFFA; a <= 16'hFFFF; a++) begin
        apply(16'(a), 2'(sp), 8'h12, 1'b1, 1'b0, 1'b0, "R7");
        apply(16'(a), 2'(sp), 8'hFF, 1'b1, 1'b0, 1'b0, "R7 bank FF");
      end
    // strobes: R8 R9, both clock phases, both sources
    for (int k = 0; k < 4; k++) begin
      @(posedge osc_clk_i); #1;
      apply(16'h1234, 2'd0, 8'hE0, 1'(k[0]), 1'b0, 1'b0, "R8 R9 osc high");
      apply(16'h1234, 2'd0, 8'hE0, 1'(k[0]), 1'b1, 1'b0, "R8 phi2 low");
      apply(16'h1234, 2'd0, 8'hE0, 1'(k[0]), 1'b1, 1'b1, "R8 R9 phi2 high");
      @(negedge osc_clk_i); #1;
      apply(16'h1234, 2'd0, 8'hE0, 1'(k[0]), 1'b0, 1'b1, "R8 R9 osc low");
      apply(16'h1234, 2'd0, 8'hE0, 1'(k[0]), 1'b1, 1'b1, "R8 R9 phi2 high osc low");
      apply(16'h1234, 2'd0, 8'hE0, 1'(k[0]), 1'b1, 1'b0, "R9 idle");
    end
    #5;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule